// File: doc/BRIEF.md
# Sizable Base Address Register

This block is one base address register of a peripheral endpoint's configuration space. Parameters fix its region size and its kind: IO or memory, 32-bit or 64-bit, and prefetchable or not. Configuration software reaches it through a small register port. The port has a write strobe, a dword select, four byte enables, write data and combinational read data. The dword select picks the low or the high half.

The address bits below the region size are tied to zero. Writing all ones and reading the value back therefore gives a mask, and that mask shows both the size of the region and its required alignment. The lowest bits are read-only type flags, so software can tell what kind of region it is before it sizes it. After software programs a base, the block compares each incoming transaction address with that base. It raises a hit when the address falls in the region and decoding for that address space is enabled.

Top module: `sizable_bar`

## Requirements
- R1: The type flags in the low dword read as follows. Bit 0 is 1 for an IO region and 0 for a memory region. For memory, bits 2:1 are 10 when the register is 64-bit and 00 when it is 32-bit, and bit 3 is 1 when the region is prefetchable. For IO, bit 1 reads 0.
- R2: The type flags are read-only. They keep their value across every write, including an all-ones write and an all-zeros write.
- R3: Address bits below the region size always read zero. After all ones are written to a 64 KiB prefetchable 64-bit memory register, the low dword reads 0xFFFF000C. After all ones are written to a 16-port IO register, the low dword reads 0xFFFFFFF1.
- R4: On a 64-bit register, dword select 1 reaches a fully writable upper address half. On a 32-bit or IO register, select 1 reads zero and ignores writes.
- R5: Byte enable bit k gates data bits 8k+7:8k. Bytes whose enable bit is clear keep their old value.
- R6: The register changes only on a clock edge where the write strobe is high.
- R7: The hit output is high when the address lies in [base, base+size), the transaction space matches the region kind, and the matching decode enable is set. Memory regions use mem_en and IO regions use io_en. A 32-bit region never hits an address with any of bits 63:32 set.
- R8: The hit output is low whenever the matching decode enable is clear or the transaction space does not match the region kind.
- R9: Reset is active low and asynchronous. It clears every base bit, so only the type flags read back.
- R10: Read data follows the dword select in the same cycle. A write is visible on the read data and on the hit output right after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Dword select: 0 low, 1 high |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword |
| mem_en | input | 1 | Memory-space decode enable |
| io_en | input | 1 | IO-space decode enable |
| txn_addr | input | 64 | Transaction address |
| txn_is_io | input | 1 | Transaction targets IO space |
| hit | output | 1 | Transaction address claimed by this region |

## Verification
A wrong writable mask or a wrong type constant shows up on the first read after reset or after a sizing write. The read port is combinational, so a fault appears in the same cycle the dword is selected. A corrupted base bit shows up in the read-back right after the write edge. It also shows up on the hit output, because the compare is combinational on the stored base. The bench therefore sweeps single-bit address flips across all 64 bits to find any comparison bit that is wrongly kept or wrongly masked.

// File: rtl/bar_pkg.sv
package bar_pkg;

  function automatic int clamp_size(input bit is_io, input bit wide, input int sz);
    int lo;
    int hi;
    lo = is_io ? 2 : 4;
    hi = wide ? 63 : 31;
    if (sz < lo) return lo;
    if (sz > hi) return hi;
    return sz;
  endfunction

  // Mask of address bits that software can write.
  function automatic logic [63:0] size_mask(input int sz, input bit wide);
    logic [63:0] m;
    m = ~((64'd1 << sz) - 64'd1);
    if (!wide) m[63:32] = 32'd0;
    return m;
  endfunction

  // Mask used for the address compare (upper bits always compared).
  function automatic logic [63:0] cmp_mask(input int sz);
    return ~((64'd1 << sz) - 64'd1);
  endfunction

  function automatic logic [31:0] type_word(input bit is_io, input bit wide, input bit pf);
    logic [31:0] t;
    t = 32'd0;
    if (is_io) begin
      t[0] = 1'b1;
    end else begin
      t[2:1] = wide ? 2'b10 : 2'b00;
      t[3]   = pf;
    end
    return t;
  endfunction

  function automatic logic [31:0] type_field(input bit is_io);
    return is_io ? 32'h3 : 32'hF;
  endfunction

  // Bits below the size boundary that are not type flags.
  function automatic logic [31:0] low_free(input int sz, input bit is_io);
    logic [63:0] below;
    below = (64'd1 << sz) - 64'd1;
    return below[31:0] & ~type_field(is_io);
  endfunction

endpackage

// File: rtl/bar_dword.sv
module bar_dword #(
  parameter logic [31:0] WMASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  for (genvar b = 0; b < 4; b++) begin : g_lane
    localparam logic [7:0] LMASK = WMASK[8*b +: 8];
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lane_q <= 8'd0;
      else if (wr && be[b])  lane_q <= wdata[8*b +: 8] & LMASK;
    end
    assign q[8*b +: 8] = lane_q;
  end
endmodule

// File: rtl/bar_match.sv
module bar_match #(
  parameter logic [63:0] CMASK = 64'hFFFF_FFFF_FFFF_0000,
  parameter bit          IS_IO = 1'b0
) (
  input  logic [63:0] base,
  input  logic [63:0] addr,
  input  logic        txn_is_io,
  input  logic        mem_en,
  input  logic        io_en,
  output logic        space_ok,
  output logic        addr_eq,
  output logic        hit
);
  always_comb begin
    if (IS_IO) space_ok = io_en && txn_is_io;
    else       space_ok = mem_en && !txn_is_io;
    addr_eq = ((addr & CMASK) == base);
    hit     = space_ok && addr_eq;
  end
endmodule

// File: rtl/bar_readback.sv
module bar_readback #(
  parameter logic [31:0] TYPE = 32'h0
) (
  input  logic        sel,
  input  logic [63:0] base,
  output logic [31:0] rdata
);
  always_comb begin
    if (sel) rdata = base[63:32];
    else     rdata = base[31:0] | TYPE;
  end
endmodule

// File: rtl/sizable_bar.sv
module sizable_bar
  import bar_pkg::*;
#(
  parameter int SIZE_LOG2 = 16,
  parameter bit IS_IO     = 1'b0,
  parameter bit IS_64     = 1'b1,
  parameter bit PREFETCH  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_en,
  input  logic        io_en,
  input  logic [63:0] txn_addr,
  input  logic        txn_is_io,
  output logic        hit
);
  localparam bit          WIDE  = IS_64 && !IS_IO;
  localparam int          SZ    = clamp_size(IS_IO, WIDE, SIZE_LOG2);
  localparam logic [63:0] WMASK = size_mask(SZ, WIDE);
  localparam logic [63:0] CMASK = cmp_mask(SZ);
  localparam logic [31:0] TYPE  = type_word(IS_IO, WIDE, PREFETCH && !IS_IO);

  // Named internal events for the checker.
  logic        wr_lo;
  logic        wr_hi;
  logic        space_ok;
  logic        addr_eq;
  logic [63:0] base_q;

  assign wr_lo = cfg_we && !cfg_sel;
  assign wr_hi = cfg_we && cfg_sel;

  bar_dword #(.WMASK(WMASK[31:0])) u_lo (
    .clk(clk), .rst_n(rst_n), .wr(wr_lo), .be(cfg_be),
    .wdata(cfg_wdata), .q(base_q[31:0])
  );

  bar_dword #(.WMASK(WMASK[63:32])) u_hi (
    .clk(clk), .rst_n(rst_n), .wr(wr_hi), .be(cfg_be),
    .wdata(cfg_wdata), .q(base_q[63:32])
  );

  bar_readback #(.TYPE(TYPE)) u_rd (
    .sel(cfg_sel), .base(base_q), .rdata(cfg_rdata)
  );

  bar_match #(.CMASK(CMASK), .IS_IO(IS_IO)) u_match (
    .base(base_q), .addr(txn_addr), .txn_is_io(txn_is_io),
    .mem_en(mem_en), .io_en(io_en),
    .space_ok(space_ok), .addr_eq(addr_eq), .hit(hit)
  );
endmodule

// File: rtl/sizable_bar_checker.sv
module sizable_bar_checker
  import bar_pkg::*;
#(
  parameter bit          IS_IO = 1'b0,
  parameter bit          WIDE  = 1'b1,
  parameter int          SZ    = 16,
  parameter logic [31:0] TYPE  = 32'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic        mem_en,
  input logic        io_en,
  input logic        txn_is_io,
  input logic        hit,
  input logic [63:0] base_q
);
  localparam logic [31:0] TFIELD = type_field(IS_IO);
  localparam logic [31:0] FREE   = low_free(SZ, IS_IO);

  assert_type_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel |-> ((cfg_rdata & TFIELD) == TYPE));

  assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel |-> ((cfg_rdata & FREE) == 32'd0));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && !WIDE) |-> (cfg_rdata == 32'd0));

  assert_hold_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(base_q));

  assert_hit_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (IS_IO ? (io_en && txn_is_io) : (mem_en && !txn_is_io)));
endmodule

bind sizable_bar sizable_bar_checker #(
  .IS_IO(IS_IO), .WIDE(WIDE), .SZ(SZ), .TYPE(TYPE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_rdata(cfg_rdata), .mem_en(mem_en), .io_en(io_en),
  .txn_is_io(txn_is_io), .hit(hit), .base_q(base_q)
);

// File: tb/sizable_bar_tb.sv
`timescale 1ns/100ps
module sizable_bar_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // 64 KiB prefetchable 64-bit memory region
  logic        m_we = 0, m_sel = 0, m_io = 0, m_men = 0, m_ien = 0, m_hit;
  logic [3:0]  m_be = 0;
  logic [31:0] m_wd = 0, m_rd;
  logic [63:0] m_addr = 0;
  // 16-port IO region
  logic        i_we = 0, i_sel = 0, i_io = 0, i_men = 0, i_ien = 0, i_hit;
  logic [3:0]  i_be = 0;
  logic [31:0] i_wd = 0, i_rd;
  logic [63:0] i_addr = 0;

  sizable_bar #(.SIZE_LOG2(16), .IS_IO(1'b0), .IS_64(1'b1), .PREFETCH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(m_we), .cfg_sel(m_sel), .cfg_be(m_be),
    .cfg_wdata(m_wd), .cfg_rdata(m_rd), .mem_en(m_men), .io_en(m_ien),
    .txn_addr(m_addr), .txn_is_io(m_io), .hit(m_hit)
  );

  sizable_bar #(.SIZE_LOG2(4), .IS_IO(1'b1), .IS_64(1'b0), .PREFETCH(1'b0)) u_dut_io (
    .clk(clk), .rst_n(rst_n), .cfg_we(i_we), .cfg_sel(i_sel), .cfg_be(i_be),
    .cfg_wdata(i_wd), .cfg_rdata(i_rd), .mem_en(i_men), .io_en(i_ien),
    .txn_addr(i_addr), .txn_is_io(i_io), .hit(i_hit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_m(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    m_we = 1; m_sel = sel; m_be = be; m_wd = d;
    @(negedge clk);
    m_we = 0;
  endtask

  task automatic wr_i(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    i_we = 1; i_sel = sel; i_be = be; i_wd = d;
    @(negedge clk);
    i_we = 0;
  endtask

  task automatic rd_m(input logic sel, output logic [31:0] v);
    m_sel = sel; #1; v = m_rd;
  endtask

  task automatic rd_i(input logic sel, output logic [31:0] v);
    i_sel = sel; #1; v = i_rd;
  endtask

  function automatic logic [31:0] bytes_of(input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = be[k] ? 8'hFF : 8'h00;
    return r;
  endfunction

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R9: reset state shows only the type flags
    rd_m(0, v); chk("R1 mem type after reset", v, 32'h0000_000C);
    rd_m(1, v); chk("R9 mem upper after reset", v, 32'h0);
    rd_i(0, v); chk("R1 io type after reset", v, 32'h0000_0001);

    // R3: sizing with all ones
    wr_m(0, 4'hF, 32'hFFFF_FFFF);
    wr_m(1, 4'hF, 32'hFFFF_FFFF);
    rd_m(0, v); chk("R3 mem size mask", v, 32'hFFFF_000C);
    rd_m(1, v); chk("R4 mem upper writable", v, 32'hFFFF_FFFF);
    wr_i(0, 4'hF, 32'hFFFF_FFFF);
    rd_i(0, v); chk("R3 io size mask", v, 32'hFFFF_FFF1);

    // R4: upper half of IO region ignores writes
    wr_i(1, 4'hF, 32'hFFFF_FFFF);
    rd_i(1, v); chk("R4 io upper reads zero", v, 32'h0);

    // R2: all-zero write keeps type flags
    wr_m(0, 4'hF, 32'h0);
    rd_m(0, v); chk("R2 mem flags after zero write", v, 32'h0000_000C);
    wr_i(0, 4'hF, 32'h0);
    rd_i(0, v); chk("R2 io flags after zero write", v, 32'h0000_0001);

    // R5: exhaustive byte-enable sweep on both halves
    for (int be = 0; be < 16; be++) begin
      wr_m(0, 4'hF, 32'h0);
      wr_m(1, 4'hF, 32'h0);
      wr_m(0, be[3:0], 32'hFFFF_FFFF);
      wr_m(1, be[3:0], 32'hA5A5_5A5A);
      rd_m(0, v); chk("R5 low byte enables", v, (bytes_of(be[3:0]) & 32'hFFFF_0000) | 32'hC);
      rd_m(1, v); chk("R5 high byte enables", v, bytes_of(be[3:0]) & 32'hA5A5_5A5A);
    end

    // R6: no write without strobe
    wr_m(0, 4'hF, 32'h1234_0000);
    @(negedge clk);
    m_we = 0; m_sel = 0; m_be = 4'hF; m_wd = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    rd_m(0, v); chk("R6 strobe low holds", v, 32'h1234_000C);

    // R10: read mux follows select in same cycle
    wr_m(1, 4'hF, 32'h0000_0001);
    m_sel = 1; #0.5; chk("R10 select high", m_rd, 32'h0000_0001);
    m_sel = 0; #0.5; chk("R10 select low", m_rd, 32'h1234_000C);

    // R7: program base 0x1_C006_0000, sweep single-bit flips
    wr_m(0, 4'hF, 32'hC006_0000);
    wr_m(1, 4'hF, 32'h0000_0001);
    base = 64'h1_C006_0000;
    m_men = 1; m_io = 0;
    m_addr = base; #1; chk("R10 R7 hit at base right after write", m_hit, 1'b1);
    for (int i = 0; i < 64; i++) begin
      m_addr = base ^ (64'd1 << i); #1;
      chk("R7 mem bit flip", m_hit, (i < 16) ? 1'b1 : 1'b0);
    end
    m_addr = base + 64'hFFFF;  #1; chk("R7 top of region", m_hit, 1'b1);
    m_addr = base + 64'h10000; #1; chk("R7 past region", m_hit, 1'b0);
    m_addr = base - 64'd1;     #1; chk("R7 below region", m_hit, 1'b0);

    // R8: enable and space gating
    m_addr = base;
    m_men = 0; #1; chk("R8 mem_en off", m_hit, 1'b0);
    m_men = 1; m_io = 1; #1; chk("R8 io txn to mem region", m_hit, 1'b0);
    m_ien = 1; #1; chk("R8 io_en does not enable mem", m_hit, 1'b0);
    m_io = 0; m_ien = 0;

    // R7 / R8 on IO region: sweep ports 0xD000..0xD03F
    wr_i(0, 4'hF, 32'h0000_D020);
    rd_i(0, v); chk("R1 io read with base", v, 32'h0000_D021);
    i_ien = 1; i_io = 1;
    for (int a = 32'hD000; a < 32'hD040; a++) begin
      i_addr = 64'(a); #1;
      chk("R7 io port sweep", i_hit, (a >= 32'hD020 && a < 32'hD030) ? 1'b1 : 1'b0);
    end
    i_addr = 64'h1_0000_D020; #1; chk("R7 32-bit region upper addr", i_hit, 1'b0);
    i_addr = 64'hD024;
    i_ien = 0; #1; chk("R8 io_en off", i_hit, 1'b0);
    i_ien = 1; i_io = 0; i_men = 1; #1; chk("R8 mem txn to io region", i_hit, 1'b0);

    // R9: asynchronous reset clears base
    @(negedge clk);
    #1 rst_n = 0; #1;
    rd_m(0, v); chk("R9 mem low cleared", v, 32'h0000_000C);
    rd_m(1, v); chk("R9 mem high cleared", v, 32'h0);
    rd_i(0, v); chk("R9 io cleared", v, 32'h0000_0001);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_m(0, v); chk("R9 stays clear after release", v, 32'h0000_000C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule